// File: doc/BRIEF.md
# Capture/Compare Interrupt Aggregator

A capture/compare timer unit raises seven kinds of events: one timer overflow, two capture channels (A, B) and four compare channels (A to D). This block latches each event strobe into a flag bit and keeps a matching per-source enable mask. It merges the enabled, pending sources into a single interrupt request line toward the CPU. The flag and enable registers share a sparse 8-bit layout, so a handler reads and clears them with the same bit masks.

The request passes through two gates: a unit-level enable and a global interrupt enable. A fixed-priority encoder also exports a 3-bit code that names the most urgent enabled pending source. The handler can therefore branch without scanning the flag register. Software clears a flag by writing a 1 to its bit position.

Top module: `ccirq_aggregator`

## Requirements
- R1: A 1 on an `evt_pulse` bit at a rising clock edge sets the flag bit at the same position. The bit layout is: capture A = 0, capture B = 1, compare A = 3, compare B = 4, compare C = 5, compare D = 6, overflow = 7.
- R2: A write with `wr_sel`=0 clears every flag bit whose `wr_data` bit is 1. Flag bits written with 0 keep their value.
- R3: When an event strobe and a write-one-clear hit the same flag bit in the same cycle, the flag ends up set.
- R4: A write with `wr_sel`=1 loads `wr_data` into the enable register. The stored value reads back on `ena_q` from the next cycle.
- R5: Bit 2 of both `flag_q` and `ena_q` always reads 0. Writes and event strobes on bit 2 have no effect.
- R6: `irq_req` is a registered level. It is 1 in the cycle after any bit is set in both flag and enable while `unit_ie` and `glb_ie` are 1. It drops one cycle after the last such bit is cleared.
- R7: If `unit_ie` or `glb_ie` is 0, `irq_req` stays 0, but flags still set and `src_code` still reflects the pending sources.
- R8: `src_code` names the highest-priority source whose flag and enable are both 1. Priority runs from highest to lowest as overflow = 0, capture A = 1, capture B = 2, compare A = 3, compare B = 4, compare C = 5, compare D = 6.
- R9: `src_code` is 7 when no source has both its flag and enable set. A flag whose enable is 0 is not considered.
- R10: After reset, both registers read 0, `irq_req` is 0 and `src_code` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 8 | Event strobes, one per flag bit position |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = flags (write-one-clear), 1 = enable mask |
| wr_data | input | 8 | Write data |
| unit_ie | input | 1 | Unit-level interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| flag_q | output | 8 | Flag register read value |
| ena_q | output | 8 | Enable register read value |
| irq_req | output | 1 | Registered interrupt request |
| src_code | output | 3 | Encoded highest-priority pending source, 7 if none |

## Verification
The assertions take each input as a clean synchronous value sampled at the rising edge. A strobe may sit on bit 2 or collide with a clear, and the checker must still hold. The bench drives every input on the falling edge and keeps each event strobe to a single cycle. It drives `wr_en` only when `wr_data` and `wr_sel` are meaningful. Collisions and writes to bit 2 are produced on purpose, so the checker's rules for those cases are exercised and not just assumed away.

// File: rtl/ccirq_pkg.sv
// Package: shared constants for the capture/compare interrupt aggregator.
// Assumes a fixed 7-source map inside an 8-bit register.
package ccirq_pkg;
    localparam int REG_W  = 8;
    localparam int N_SRC  = 7;
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] NONE_CODE = '1;

    // Bit position of each source, indexed by priority (0 = most urgent).
    localparam int PRIO_POS [N_SRC] = '{7, 0, 1, 3, 4, 5, 6};

    // Mask of implemented bit positions, derived from the priority map.
    function automatic logic [REG_W-1:0] valid_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < N_SRC; p++) m[PRIO_POS[p]] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] VALID_MASK = valid_mask();
endpackage

// File: rtl/ccirq_flag_reg.sv
// Flag and enable registers.
// Flags: set by event strobes, cleared by write-one (a set beats a clear).
// Enable: a plain load on write.
// Unimplemented positions are tied to 0.
// Assumes synchronous active-low reset.
module ccirq_flag_reg
    import ccirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_pulse,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] flag_q,
    output logic [REG_W-1:0] ena_q
);
    logic flag_clr_en;
    logic ena_ld_en;

    // Decode which register a write targets.
    always_comb begin
        flag_clr_en = wr_en && !wr_sel;
        ena_ld_en   = wr_en &&  wr_sel;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (VALID_MASK[i]) begin : g_used
            // Flag bit: hold, clear on write-one, set on event (set has priority).
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[i] <= 1'b0;
                else if (evt_pulse[i])
                    flag_q[i] <= 1'b1;
                else if (flag_clr_en && wr_data[i])
                    flag_q[i] <= 1'b0;
            end
            // Enable bit: load on enable-register write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ena_q[i] <= 1'b0;
                else if (ena_ld_en)
                    ena_q[i] <= wr_data[i];
            end
        end else begin : g_hole
            assign flag_q[i] = 1'b0;
            assign ena_q[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/ccirq_prio_enc.sv
// Fixed-priority encoder over pending, enabled sources.
// Outputs the priority index of the most urgent source, or NONE_CODE.
// Assumes PRIO_POS lists the bit positions from most to least urgent.
module ccirq_prio_enc
    import ccirq_pkg::*;
(
    input  logic [REG_W-1:0]  pend,
    output logic [CODE_W-1:0] code,
    output logic              any
);
    // Scan from least to most urgent so the most urgent match wins.
    always_comb begin
        code = NONE_CODE;
        for (int p = N_SRC - 1; p >= 0; p--) begin
            if (pend[PRIO_POS[p]]) code = CODE_W'(p);
        end
        any = |pend;
    end
endmodule

// File: rtl/ccirq_req_gate.sv
// Gates the merged request with the unit and global enables and registers it.
// Assumes synchronous active-low reset.
module ccirq_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic unit_ie,
    input  logic glb_ie,
    output logic irq_req
);
    // Registered, gated interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_req <= 1'b0;
        else
            irq_req <= any_pend && unit_ie && glb_ie;
    end
endmodule

// File: rtl/ccirq_aggregator.sv
// Top: capture/compare interrupt aggregator.
// Latches seven event sources, masks them, gates the merged request and
// reports the most urgent pending source as a 3-bit code.
// Assumes all inputs are synchronous to clk.
module ccirq_aggregator
    import ccirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt_pulse,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              unit_ie,
    input  logic              glb_ie,
    output logic [REG_W-1:0]  flag_q,
    output logic [REG_W-1:0]  ena_q,
    output logic              irq_req,
    output logic [CODE_W-1:0] src_code
);
    logic [REG_W-1:0] pend;
    logic             any_pend;

    ccirq_flag_reg u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .flag_q    (flag_q),
        .ena_q     (ena_q)
    );

    // Sources that are both flagged and enabled.
    always_comb pend = flag_q & ena_q;

    ccirq_prio_enc u_enc (
        .pend (pend),
        .code (src_code),
        .any  (any_pend)
    );

    ccirq_req_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (any_pend),
        .unit_ie  (unit_ie),
        .glb_ie   (glb_ie),
        .irq_req  (irq_req)
    );
endmodule

// File: rtl/ccirq_checker.sv
// Checker: temporal properties of the aggregator, observed at its ports.
// Bound into every instance of ccirq_aggregator.
module ccirq_checker
    import ccirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  evt_pulse,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [REG_W-1:0]  wr_data,
    input logic              unit_ie,
    input logic              glb_ie,
    input logic [REG_W-1:0]  flag_q,
    input logic [REG_W-1:0]  ena_q,
    input logic              irq_req,
    input logic [CODE_W-1:0] src_code
);
    // R1 / R3: a strobe always leaves its flag set, even against a clear.
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & VALID_MASK) != '0) |=>
        ((flag_q & $past(evt_pulse & VALID_MASK)) == $past(evt_pulse & VALID_MASK)));

    // R2: write-one-clear without a colliding strobe clears the bit.
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && ((wr_data & ~evt_pulse) != '0)) |=>
        ((flag_q & $past(wr_data & ~evt_pulse)) == '0));

    // R2: with no strobe and no flag write, the flags hold.
    a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse == '0 && !(wr_en && !wr_sel)) |=> $stable(flag_q));

    // R4 / R5: the enable register loads the implemented bits of the write.
    a_r4_ena_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (ena_q == $past(wr_data & VALID_MASK)));

    // R5: the hole position never reads 1.
    a_r5_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[2] == 1'b0) && (ena_q[2] == 1'b0));

    // R6 / R7: the request follows the gated pending set one cycle later.
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_req == ($past((flag_q & ena_q) != '0) && $past(unit_ie && glb_ie))));

    // R9: the code is 7 exactly when nothing enabled is pending.
    a_r9_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        (src_code == NONE_CODE) == ((flag_q & ena_q) == '0));

    // R8: a reported source is itself pending.
    a_r8_code_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (src_code != NONE_CODE) |-> ((flag_q & ena_q) != '0));
endmodule

bind ccirq_aggregator ccirq_checker u_chk (.*);

// File: tb/sim_ccirq_aggregator.sv
module sim_ccirq_aggregator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_pulse = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       unit_ie = 1'b0;
    logic       glb_ie = 1'b0;
    logic [7:0] flag_q, ena_q;
    logic       irq_req;
    logic [2:0] src_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    ccirq_aggregator u0 (.*);

    // {set, ena, unit, glb, exp_code, exp_irq}
    typedef struct packed {
        logic [7:0] set;
        logic [7:0] ena;
        logic       unit;
        logic       glb;
        logic [2:0] code;
        logic       irq;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{8'h80, 8'hFF, 1'b1, 1'b1, 3'd0, 1'b1},   // R8 overflow
        '{8'h01, 8'hFF, 1'b1, 1'b1, 3'd1, 1'b1},   // R8 capture A
        '{8'h02, 8'hFF, 1'b1, 1'b1, 3'd2, 1'b1},   // R8 capture B
        '{8'h08, 8'hFF, 1'b1, 1'b1, 3'd3, 1'b1},   // R8 compare A
        '{8'h10, 8'hFF, 1'b1, 1'b1, 3'd4, 1'b1},   // R8 compare B
        '{8'h20, 8'hFF, 1'b1, 1'b1, 3'd5, 1'b1},   // R8 compare C
        '{8'h40, 8'hFF, 1'b1, 1'b1, 3'd6, 1'b1},   // R8 compare D
        '{8'hFB, 8'hFF, 1'b1, 1'b1, 3'd0, 1'b1},   // R8 all pending
        '{8'h7B, 8'hFF, 1'b1, 1'b1, 3'd1, 1'b1},   // R8 all but overflow
        '{8'h78, 8'h70, 1'b1, 1'b1, 3'd4, 1'b1},   // R9 masked compare A
        '{8'h80, 8'h7F, 1'b1, 1'b1, 3'd7, 1'b0},   // R9 only masked source
        '{8'hFF, 8'hFF, 1'b0, 1'b1, 3'd0, 1'b0},   // R7 unit gate
        '{8'hFF, 8'hFF, 1'b1, 1'b0, 3'd0, 1'b0},   // R7 global gate
        '{8'h04, 8'hFF, 1'b1, 1'b1, 3'd7, 1'b0}    // R5 strobe on hole
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R10: reset state
        check("R10 flags", flag_q, 8'h00);
        check("R10 ena", ena_q, 8'h00);
        check("R10 irq", {7'b0, irq_req}, 8'h00);
        check("R10 code", {5'b0, src_code}, 8'h07);

        // Table walk: R1 R7 R8 R9
        foreach (VECS[k]) begin
            wr(1'b0, 8'hFF);
            wr(1'b1, VECS[k].ena);
            unit_ie = VECS[k].unit; glb_ie = VECS[k].glb;
            evt_pulse = VECS[k].set;
            tick();
            evt_pulse = '0;
            tick();
            check("R1 flags", flag_q, VECS[k].set & 8'hFB);
            check("R4 ena", ena_q, VECS[k].ena & 8'hFB);
            check("R8 code", {5'b0, src_code}, {5'b0, VECS[k].code});
            check("R6 irq", {7'b0, irq_req}, {7'b0, VECS[k].irq});
        end

        // R5: write to bit 2 of enable ignored
        wr(1'b1, 8'h04);
        check("R5 ena hole", ena_q, 8'h00);

        // R2: zero bits of a clear write keep flags; ones clear
        wr(1'b1, 8'hFF);
        unit_ie = 1'b1; glb_ie = 1'b1;
        evt_pulse = 8'hFF; tick(); evt_pulse = '0;
        wr(1'b0, 8'h00);
        check("R2 zero write", flag_q, 8'hFB);
        wr(1'b0, 8'h81);
        check("R2 partial clear", flag_q, 8'h7A);
        check("R8 code after clear", {5'b0, src_code}, 8'h02);

        // R3: set beats clear in the same cycle
        evt_pulse = 8'h80; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hFF;
        tick();
        evt_pulse = '0; wr_en = 1'b0; wr_data = '0;
        check("R3 collision", flag_q, 8'h80);

        // R6: request drops one cycle after the last flag clears
        tick();
        check("R6 irq held", {7'b0, irq_req}, 8'h01);
        wr(1'b0, 8'h80);
        check("R6 flags cleared", flag_q, 8'h00);
        check("R6 irq still high", {7'b0, irq_req}, 8'h01);
        check("R9 code none", {5'b0, src_code}, 8'h07);
        tick();
        check("R6 irq dropped", {7'b0, irq_req}, 8'h00);

        // R10: reset mid-run returns to reset state
        evt_pulse = 8'h10; tick(); evt_pulse = '0;
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check("R10 flags after reset", flag_q, 8'h00);
        check("R10 ena after reset", ena_q, 8'h00);
        check("R10 code after reset", {5'b0, src_code}, 8'h07);

        finish_run();
    end
endmodule